// File: doc/BRIEF.md
# Bit Scan and Zero Count Unit

This execution unit takes one source operand and returns the position of its lowest or highest set bit (the scan forms), or the number of trailing or leading zero bits (the count forms). Operands are 16, 32 or 64 bits wide. Bits of the source above the selected operand width are ignored. A single direction input picks forward (low end) or reverse (high end) work.

The scan and count forms share one opcode per direction. A repeat-prefix flag turns a scan into the matching count only when the feature-enable bit for that count is set. Otherwise the instruction stays a plain scan. The two families behave differently on an all-zero source. A scan then leaves the destination alone and raises the zero flag. A count writes the operand width as its result and raises the carry flag.

The unit has one register stage. A request presented with `in_valid` produces its result, write enable and flags one clock later, with `out_valid` set. A new request can be accepted on every cycle.

Top module: `bsz_unit`

## Requirements
- R1: While reset is asserted and on the first sample after its release, `out_valid`, `wr_en`, `zf` and `cf` are 0.
- R2: `out_valid` equals `in_valid` delayed by exactly one clock. `wr_en`, `zf` and `cf` are 0 in any cycle where `out_valid` is 0.
- R3: `op_size` selects the operand width: 2'b00 gives 16 bits, 2'b01 gives 32 bits, and 2'b10 or 2'b11 give 64 bits. Source bits at or above that width have no effect on any output.
- R4: A forward scan of a nonzero source returns the index of the lowest set bit, zero-extended to 64 bits, with `wr_en`=1 and `zf`=0.
- R5: A reverse scan of a nonzero source returns the index of the highest set bit, zero-extended, with `wr_en`=1 and `zf`=0.
- R6: A scan of a zero source (after masking) gives `zf`=1 and `wr_en`=0, and the result equals the `old_dst` input of that request.
- R7: Count mode is used only when `rep_pfx`=1 and the enable for the selected direction is 1. That enable is `tz_en` for forward (`op_rev`=0) and `lz_en` for reverse (`op_rev`=1). The enable of the other direction has no effect. In every other case the scan behaviour of R4 to R6 applies.
- R8: A trailing-zero count returns the operand width for a zero source and the lowest set-bit index otherwise.
- R9: A leading-zero count returns the operand width for a zero source. Otherwise it returns the width minus one minus the highest set-bit index.
- R10: The count forms always assert `wr_en`. They zero-extend the count to 64 bits, and set `zf` exactly when the count is 0.
- R11: `cf` is 1 only for a count form on a zero source. It is 0 for every scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| op_rev | input | 1 | 0: forward/trailing, 1: reverse/leading |
| rep_pfx | input | 1 | Repeat prefix present |
| tz_en | input | 1 | Trailing-zero count feature enabled |
| lz_en | input | 1 | Leading-zero count feature enabled |
| op_size | input | 2 | Operand width select |
| src | input | 64 | Source operand |
| old_dst | input | 64 | Current destination value |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Result value |
| wr_en | output | 1 | Destination write enable |
| zf | output | 1 | Zero flag |
| cf | output | 1 | Carry flag |

## Verification
The bench sweeps every combination of direction, prefix, both enables and all four size codes. For each combination it applies a zero source and sources that are zero only inside the window. A design that forgot the size mask would report a scan hit or a wrong count for the second kind. A single set bit is walked across all 64 positions to catch off-by-one errors at the width edges. A count of 0 when the top or bottom bit is set exposes a wrong flag. A design that picked the wrong enable for a direction, or that wrote the destination on a zero scan, shows a changed result or write enable. A one-cycle gap in `in_valid` catches stale valid or write-enable outputs.

// File: rtl/bsz_pkg.sv
package bsz_pkg;
  typedef enum logic [1:0] {
    SZ_W16 = 2'b00,
    SZ_W32 = 2'b01,
    SZ_W64 = 2'b10,
    SZ_W64B = 2'b11
  } opsz_e;

  // Operand width in bits for a size code, clamped to the datapath width.
  function automatic int unsigned size_bits(input logic [1:0] code, input int unsigned xlen);
    int unsigned w;
    case (code)
      2'b00:   w = 16;
      2'b01:   w = 32;
      default: w = 64;
    endcase
    return (w > xlen) ? xlen : w;
  endfunction
endpackage

// File: rtl/bsz_opmask.sv
module bsz_opmask #(
  parameter int unsigned XLEN = 64,
  localparam int unsigned CW = $clog2(XLEN) + 1
) (
  input  logic [XLEN-1:0] src_i,
  input  logic [1:0]      size_i,
  output logic [XLEN-1:0] masked_o,
  output logic [CW-1:0]   width_o
);
  import bsz_pkg::*;

  int unsigned w_bits;
  logic [XLEN-1:0] keep;

  always_comb begin
    w_bits   = size_bits(size_i, XLEN);
    keep     = {XLEN{1'b1}} >> (XLEN - w_bits);
    masked_o = src_i & keep;
    width_o  = CW'(w_bits);
  end
endmodule

// File: rtl/bsz_prienc.sv
module bsz_prienc #(
  parameter int unsigned W = 64,
  parameter bit HIGH = 1'b0,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  assign any_o = |vec_i;

  generate
    if (HIGH) begin : g_high
      // Last hit while climbing wins: highest set bit.
      always_comb begin
        idx_o = '0;
        for (int i = 0; i < W; i++)
          if (vec_i[i]) idx_o = IW'(i);
      end
    end else begin : g_low
      // Last hit while descending wins: lowest set bit.
      always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--)
          if (vec_i[i]) idx_o = IW'(i);
      end
    end
  endgenerate
endmodule

// File: rtl/bsz_unit.sv
module bsz_unit #(
  parameter int unsigned XLEN = 64,
  localparam int unsigned IW = $clog2(XLEN),
  localparam int unsigned CW = IW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            op_rev,
  input  logic            rep_pfx,
  input  logic            tz_en,
  input  logic            lz_en,
  input  logic [1:0]      op_size,
  input  logic [XLEN-1:0] src,
  input  logic [XLEN-1:0] old_dst,
  output logic            out_valid,
  output logic [XLEN-1:0] result,
  output logic            wr_en,
  output logic            zf,
  output logic            cf
);
  // Named internal events
  logic [XLEN-1:0] src_m;
  logic [CW-1:0]   width;
  logic [IW-1:0]   lo_idx, hi_idx;
  logic            lo_any, hi_any;
  logic            src_zero;
  logic            count_mode;
  logic [CW-1:0]   count_val;
  logic [IW-1:0]   scan_idx;
  logic [XLEN-1:0] nxt_result;
  logic            nxt_wr, nxt_zf, nxt_cf;
  logic            cnt_q;
  logic [CW-1:0]   width_q;

  bsz_opmask #(.XLEN(XLEN)) u_mask (
    .src_i(src), .size_i(op_size), .masked_o(src_m), .width_o(width)
  );

  bsz_prienc #(.W(XLEN), .HIGH(1'b0)) u_lo (
    .vec_i(src_m), .idx_o(lo_idx), .any_o(lo_any)
  );

  bsz_prienc #(.W(XLEN), .HIGH(1'b1)) u_hi (
    .vec_i(src_m), .idx_o(hi_idx), .any_o(hi_any)
  );

  always_comb begin
    src_zero   = ~lo_any;
    count_mode = rep_pfx & (op_rev ? lz_en : tz_en);
    scan_idx   = op_rev ? hi_idx : lo_idx;
    if (src_zero)
      count_val = width;
    else if (op_rev)
      count_val = width - CW'(1) - CW'(hi_idx);
    else
      count_val = CW'(lo_idx);

    if (count_mode) begin
      nxt_result = {{(XLEN-CW){1'b0}}, count_val};
      nxt_wr     = 1'b1;
      nxt_zf     = (count_val == '0);
      nxt_cf     = src_zero;
    end else begin
      nxt_result = src_zero ? old_dst : {{(XLEN-IW){1'b0}}, scan_idx};
      nxt_wr     = ~src_zero;
      nxt_zf     = src_zero;
      nxt_cf     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      wr_en     <= 1'b0;
      zf        <= 1'b0;
      cf        <= 1'b0;
      cnt_q     <= 1'b0;
      width_q   <= '0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= in_valid & nxt_wr;
      zf        <= in_valid & nxt_zf;
      cf        <= in_valid & nxt_cf;
      cnt_q     <= in_valid & count_mode;
      if (in_valid) begin
        result  <= nxt_result;
        width_q <= width;
      end
    end
  end

  // Assertions
  p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_flags_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !wr_en && !zf && !cf);
  p_lo_hi_agree_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lo_any == hi_any && lo_idx <= hi_idx);
  p_scan_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !cnt_q && !zf |-> wr_en && result < {{(XLEN-CW){1'b0}}, width_q});
  p_scan_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !count_mode && src_zero |=> !wr_en && zf && result == $past(old_dst));
  p_count_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cnt_q |-> wr_en && result <= {{(XLEN-CW){1'b0}}, width_q});
  p_count_zf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cnt_q |-> zf == (result == '0));
  p_cf_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cf |-> cnt_q && result == {{(XLEN-CW){1'b0}}, width_q});
  p_cf_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && count_mode && src_zero |=> cf);
endmodule

// File: tb/tb_bsz_unit.sv
module tb_bsz_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        op_rev = 1'b0, rep_pfx = 1'b0, tz_en = 1'b0, lz_en = 1'b0;
  logic [1:0]  op_size = 2'b00;
  logic [63:0] src = '0, old_dst = '0;
  logic        out_valid, wr_en, zf, cf;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bsz_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_rev(op_rev),
    .rep_pfx(rep_pfx), .tz_en(tz_en), .lz_en(lz_en), .op_size(op_size),
    .src(src), .old_dst(old_dst), .out_valid(out_valid), .result(result),
    .wr_en(wr_en), .zf(zf), .cf(cf)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, then check at the next falling edge.
  task automatic run(input bit rev, input bit rp, input bit tz, input bit lz,
                     input logic [1:0] sz, input logic [63:0] s, input logic [63:0] od);
    int w, lo, hi, cnt;
    bit is_cnt, zero;
    logic [63:0] exp_res;
    bit exp_wr, exp_zf, exp_cf;
    w = (sz == 2'b00) ? 16 : (sz == 2'b01) ? 32 : 64;           // R3
    lo = -1; hi = -1;
    for (int k = 0; k < w; k++) if (s[k]) begin hi = k; if (lo < 0) lo = k; end
    zero = (lo < 0);
    is_cnt = rp && (rev ? lz : tz);                               // R7
    if (is_cnt) begin
      cnt = zero ? w : (rev ? (w - 1 - hi) : lo);                 // R8 R9
      exp_res = 64'(cnt); exp_wr = 1; exp_zf = (cnt == 0); exp_cf = zero; // R10
    end else if (zero) begin
      exp_res = od; exp_wr = 0; exp_zf = 1; exp_cf = 0;           // R6
    end else begin
      exp_res = 64'(rev ? hi : lo); exp_wr = 1; exp_zf = 0; exp_cf = 0; // R4 R5
    end
    in_valid = 1; op_rev = rev; rep_pfx = rp; tz_en = tz; lz_en = lz;
    op_size = sz; src = s; old_dst = od;
    @(negedge clk);
    chk(out_valid === 1'b1, "R2 out_valid", 64'(out_valid), 64'd1);
    chk(result === exp_res, is_cnt ? (rev ? "R9 result" : "R8 result")
                                  : (zero ? "R6 result" : (rev ? "R5 result" : "R4 result")),
        result, exp_res);
    chk(wr_en === exp_wr, is_cnt ? "R10 wr_en" : "R6 wr_en", 64'(wr_en), 64'(exp_wr));
    chk(zf === exp_zf, is_cnt ? "R10 zf" : "R6 zf", 64'(zf), 64'(exp_zf));
    chk(cf === exp_cf, "R11 cf", 64'(cf), 64'(exp_cf));
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] lfsr;
    lfsr = 64'hACE1_2468_9BDF_1357;
    repeat (3) @(negedge clk);
    chk(out_valid === 0 && wr_en === 0, "R1 reset outputs", {62'd0, out_valid, wr_en}, 64'd0);
    chk(zf === 0 && cf === 0, "R1 reset flags", {62'd0, zf, cf}, 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid === 0 && wr_en === 0 && zf === 0 && cf === 0, "R1 after release",
        {60'd0, out_valid, wr_en, zf, cf}, 64'd0);

    for (int sz = 0; sz < 4; sz++) begin
      for (int m = 0; m < 16; m++) begin
        bit rv, rp, tz, lz;
        {rv, rp, tz, lz} = 4'(m);
        run(rv, rp, tz, lz, 2'(sz), 64'd0, 64'h1111_2222_3333_4444);
        // zero inside the window, bits above it set (R3)
        run(rv, rp, tz, lz, 2'(sz), 64'hFFFF_FFFF_FFFF_0000, 64'h5555_0000_AAAA_0001);
        run(rv, rp, tz, lz, 2'(sz), 64'hFFFF_FFFF_0000_0000, 64'hDEAD_BEEF_0000_0007);
        run(rv, rp, tz, lz, 2'(sz), 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
        for (int b = 0; b < 64; b++)
          run(rv, rp, tz, lz, 2'(sz), 64'd1 << b, 64'h0BAD_0BAD_0BAD_0BAD);
        for (int r = 0; r < 8; r++) begin
          lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
          run(rv, rp, tz, lz, 2'(sz), lfsr & (lfsr >> r), lfsr);
        end
      end
    end

    // R2: a gap in in_valid clears out_valid and all strobes.
    in_valid = 0;
    @(negedge clk);
    chk(out_valid === 0, "R2 gap out_valid", 64'(out_valid), 64'd0);
    chk(wr_en === 0 && zf === 0 && cf === 0, "R2 gap strobes", {61'd0, wr_en, zf, cf}, 64'd0);
    run(1'b0, 1'b1, 1'b1, 1'b0, 2'b01, 64'h0000_0000_0001_0000, 64'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule